// File: doc/BRIEF.md
# Decimal-Capable Accumulator ALU

This block is the purely combinational arithmetic and logic stage of a small accumulator machine. Each evaluation takes an operation code, a reference word (the accumulator, or an index register for compares), a second operand, the current carry flag and the decimal-mode flag. It returns a result word plus a proposed next value for the carry, zero, negative and overflow flags. Every flag value comes with its own write enable, so the surrounding status register keeps any flag the operation leaves alone.

Add and subtract run in two's-complement binary by default. When decimal mode is set they work on packed binary-coded-decimal digits instead, with correction applied per digit and the carry chained between digits. Zero, negative and overflow are still taken from the binary form of the same operation. Shifts, rotates, increment, decrement and pass-through act on the operand word, so an accumulator shift is done by presenting the accumulator as the operand. The word width is a parameter in whole digits, and the decimal path can be removed at elaboration.

Top module: `dec_alu`

## Requirements
- R1: With op_sel=0 (add) and dec_mode=0, result is (ref_val + opnd + carry_in) mod 256; c_out is 1 exactly when that sum is above 255; zero is (result==0); negative is result bit 7.
- R2: For add (op_sel=0) and subtract (op_sel=1), v_out is 1 exactly when the signed value ref_val + opnd + carry_in (add) or ref_val - opnd - (1 - carry_in) (subtract) lies outside -128..127, using the binary form even in decimal mode.
- R3: With op_sel=1 (subtract) and dec_mode=0, result is (ref_val - opnd - (1 - carry_in)) mod 256, and c_out is 1 exactly when no borrow occurs (the unreduced difference is 0 or more).
- R4: With op_sel=0 and dec_mode=1 and both words valid packed BCD, each result digit is the decimal sum digit: low sum = low digits + carry_in, a low sum of 10 or more adds one to the high sum, each digit is kept modulo 10, and c_out is 1 when the high sum is above 9.
- R5: With op_sel=1 and dec_mode=1 and valid BCD words, each digit is 10 + ref digit - operand digit - borrow_in (low borrow_in = 1 - carry_in), a value below 10 borrows from the next digit, each digit is kept modulo 10, and c_out is 1 when the high biased value is 10 or more.
- R6: In decimal mode, zero and negative for add and subtract come from the binary result of the same operation, not from the decimal result.
- R7: Compare (op_sel=2) sets zero and negative from (ref_val - opnd) mod 256 and c_out = (ref_val >= opnd) unsigned; result equals ref_val and overflow is not written.
- R8: Bit test (op_sel=3) sets zero = ((ref_val AND opnd) == 0), negative = opnd bit 7, overflow = opnd bit 6; carry is not written and result equals ref_val.
- R9: AND (op_sel=4), OR (5) and XOR (6) return ref_val combined with opnd and write only zero and negative; dec_mode changes no operation other than add and subtract.
- R10: Shift left (7), shift right (8), rotate left (9) and rotate right (10) act on opnd; the bit shifted out goes to c_out; a rotate puts carry_in in the vacated bit (bit 0 left, bit 7 right), a shift puts 0; zero and negative follow the result.
- R11: Increment (11) and decrement (12) return opnd plus or minus one modulo 256, pass (13) returns opnd; all three write only zero and negative.
- R12: Write enables: add and subtract raise all four; compare raises carry, zero and negative; bit test raises zero, negative and overflow; shifts and rotates raise carry, zero and negative; codes 14 and 15 raise none and return ref_val. A flag value output carries meaning only while its enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code |
| ref_val | input | WIDTH | Accumulator or compare register |
| opnd | input | WIDTH | Second operand, or the word to shift, step or pass |
| carry_in | input | 1 | Current carry flag |
| dec_mode | input | 1 | Decimal-mode flag |
| result | output | WIDTH | Result word |
| c_out | output | 1 | Next carry value |
| c_we | output | 1 | Carry write enable |
| z_out | output | 1 | Next zero value |
| z_we | output | 1 | Zero write enable |
| n_out | output | 1 | Next negative value |
| n_we | output | 1 | Negative write enable |
| v_out | output | 1 | Next overflow value |
| v_we | output | 1 | Overflow write enable |

## Verification
Every output is combinational, so each result and flag is due in the same cycle as its stimulus, with no register in between. The bench applies one vector at a time at a point well clear of any clock edge and reads the outputs half a time unit later, once all of them have settled. Add, subtract and compare are swept over every pair of binary words, decimal add and subtract over every pair of valid two-digit BCD values with both carries, and the remaining codes over a strided reference range against every operand.

// File: rtl/alu_pkg.sv
package alu_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_CMP  = 4'd2,
      OP_BIT  = 4'd3,
      OP_AND  = 4'd4,
      OP_OR   = 4'd5,
      OP_XOR  = 4'd6,
      OP_SHL  = 4'd7,
      OP_SHR  = 4'd8,
      OP_ROL  = 4'd9,
      OP_ROR  = 4'd10,
      OP_INC  = 4'd11,
      OP_DEC  = 4'd12,
      OP_PASS = 4'd13,
      OP_IDL0 = 4'd14,
      OP_IDL1 = 4'd15
   } alu_op_e;

   localparam int DIGIT_W = 4;

endpackage

// File: rtl/alu_bin_unit.sv
// Binary adder used for add, subtract and compare.
module alu_bin_unit #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   logic [WIDTH:0]   full;

   assign b_eff = sub ? ~b : b;
   assign full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
   assign sum   = full[WIDTH-1:0];
   assign cout  = full[WIDTH];
   // signed overflow: like-signed inputs giving an unlike-signed sum
   assign ovf   = (a[MSB] == b_eff[MSB]) && (full[MSB] != a[MSB]);
endmodule

// File: rtl/alu_bcd_unit.sv
// Packed-decimal adder/subtractor, one corrected digit slice per nibble.
module alu_bcd_unit
   import alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   localparam int DIGITS = WIDTH / DIGIT_W;

   // chain[d] is the carry (add) or no-borrow (subtract) into digit d
   logic [DIGITS:0] chain;
   assign chain[0] = cin;

   for (genvar d = 0; d < DIGITS; d++) begin : g_digit
      logic [DIGIT_W-1:0] ad, bd;
      logic [5:0]         add_raw;
      logic signed [5:0]  sub_raw;
      logic [DIGIT_W-1:0] add_dig, sub_dig;
      logic               add_cy, sub_cy;

      assign ad = a[d*DIGIT_W +: DIGIT_W];
      assign bd = b[d*DIGIT_W +: DIGIT_W];

      // add: raw digit sum 0..31, reduced modulo ten
      assign add_raw = {2'b00, ad} + {2'b00, bd} + {5'd0, chain[d]};
      assign add_cy  = (add_raw >= 6'd10);
      always_comb begin
         if (add_raw >= 6'd30)      add_dig = DIGIT_W'(add_raw - 6'd30);
         else if (add_raw >= 6'd20) add_dig = DIGIT_W'(add_raw - 6'd20);
         else if (add_raw >= 6'd10) add_dig = DIGIT_W'(add_raw - 6'd10);
         else                       add_dig = DIGIT_W'(add_raw);
      end

      // subtract: digit biased by ten, range -6..25
      assign sub_raw = 6'sd10 + $signed({2'b00, ad}) - $signed({2'b00, bd})
                       - $signed({5'd0, ~chain[d]});
      assign sub_cy  = (sub_raw >= 6'sd10);
      always_comb begin
         if (sub_raw < 6'sd0)        sub_dig = DIGIT_W'(sub_raw + 6'sd10);
         else if (sub_raw >= 6'sd20) sub_dig = DIGIT_W'(sub_raw - 6'sd20);
         else if (sub_raw >= 6'sd10) sub_dig = DIGIT_W'(sub_raw - 6'sd10);
         else                        sub_dig = DIGIT_W'(sub_raw);
      end

      assign sum[d*DIGIT_W +: DIGIT_W] = sub ? sub_dig : add_dig;
      assign chain[d+1]                = sub ? sub_cy  : add_cy;
   end

   assign cout = chain[DIGITS];
endmodule

// File: rtl/alu_shift_unit.sv
// One-place shifter/rotator on the operand word.
module alu_shift_unit #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] din,
   input  logic             cin,
   input  logic             left,
   input  logic             rotate,
   output logic [WIDTH-1:0] dout,
   output logic             cout
);
   localparam int MSB = WIDTH - 1;

   logic fill;
   assign fill = rotate & cin;

   always_comb begin
      if (left) begin
         dout = {din[MSB-1:0], fill};
         cout = din[MSB];
      end else begin
         dout = {fill, din[MSB:1]};
         cout = din[0];
      end
   end
endmodule

// File: rtl/dec_alu.sv
module dec_alu
   import alu_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter bit DECIMAL_EN = 1'b1
) (
   input  logic [OP_W-1:0]  op_sel,
   input  logic [WIDTH-1:0] ref_val,
   input  logic [WIDTH-1:0] opnd,
   input  logic             carry_in,
   input  logic             dec_mode,
   output logic [WIDTH-1:0] result,
   output logic             c_out,
   output logic             c_we,
   output logic             z_out,
   output logic             z_we,
   output logic             n_out,
   output logic             n_we,
   output logic             v_out,
   output logic             v_we
);
   localparam int MSB    = WIDTH - 1;
   localparam bit DEC_ON = DECIMAL_EN;

   if ((WIDTH % DIGIT_W) != 0 || WIDTH < 8) begin : g_bad_width
      $error("dec_alu: WIDTH must be a multiple of %0d and at least 8", DIGIT_W);
   end

   alu_op_e op;
   assign op = alu_op_e'(op_sel);

   // shared binary adder: add, subtract, compare
   logic             bin_sub, bin_cin, bin_cout, bin_ovf;
   logic [WIDTH-1:0] bin_sum;

   assign bin_sub = (op != OP_ADD);
   assign bin_cin = (op == OP_CMP) ? 1'b1 : carry_in;

   alu_bin_unit #(.WIDTH(WIDTH)) bin_i (
      .a(ref_val), .b(opnd), .cin(bin_cin), .sub(bin_sub),
      .sum(bin_sum), .cout(bin_cout), .ovf(bin_ovf)
   );

   // decimal path, present only when enabled
   logic [WIDTH-1:0] dec_sum;
   logic             dec_cout;
   logic             use_dec;

   if (DECIMAL_EN) begin : g_dec
      alu_bcd_unit #(.WIDTH(WIDTH)) bcd_i (
         .a(ref_val), .b(opnd), .cin(carry_in), .sub(bin_sub),
         .sum(dec_sum), .cout(dec_cout)
      );
   end else begin : g_nodec
      assign dec_sum  = bin_sum;
      assign dec_cout = bin_cout;
   end

   assign use_dec = dec_mode & DEC_ON;

   // shifter
   logic [WIDTH-1:0] sh_res;
   logic             sh_cout, sh_left, sh_rot;

   assign sh_left = (op == OP_SHL) || (op == OP_ROL);
   assign sh_rot  = (op == OP_ROL) || (op == OP_ROR);

   alu_shift_unit #(.WIDTH(WIDTH)) shf_i (
      .din(opnd), .cin(carry_in), .left(sh_left), .rotate(sh_rot),
      .dout(sh_res), .cout(sh_cout)
   );

   // result, flag source word and enables
   logic [WIDTH-1:0] zn_src;

   always_comb begin
      result = ref_val;
      zn_src = ref_val;
      c_out  = 1'b0;
      v_out  = 1'b0;
      c_we   = 1'b0;
      z_we   = 1'b0;
      n_we   = 1'b0;
      v_we   = 1'b0;
      unique case (op)
         OP_ADD, OP_SUB: begin
            result = use_dec ? dec_sum : bin_sum;
            zn_src = bin_sum;
            c_out  = use_dec ? dec_cout : bin_cout;
            v_out  = bin_ovf;
            {c_we, z_we, n_we, v_we} = 4'b1111;
         end
         OP_CMP: begin
            zn_src = bin_sum;
            c_out  = bin_cout;
            {c_we, z_we, n_we} = 3'b111;
         end
         OP_BIT: begin
            zn_src = ref_val & opnd;
            v_out  = opnd[MSB-1];
            {z_we, n_we, v_we} = 3'b111;
         end
         OP_AND, OP_OR, OP_XOR: begin
            if (op == OP_AND)     result = ref_val & opnd;
            else if (op == OP_OR) result = ref_val | opnd;
            else                  result = ref_val ^ opnd;
            zn_src = result;
            {z_we, n_we} = 2'b11;
         end
         OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
            result = sh_res;
            zn_src = sh_res;
            c_out  = sh_cout;
            {c_we, z_we, n_we} = 3'b111;
         end
         OP_INC, OP_DEC, OP_PASS: begin
            if (op == OP_INC)      result = opnd + WIDTH'(1);
            else if (op == OP_DEC) result = opnd - WIDTH'(1);
            else                   result = opnd;
            zn_src = result;
            {z_we, n_we} = 2'b11;
         end
         default: ;
      endcase
   end

   assign z_out = (zn_src == '0);
   assign n_out = (op == OP_BIT) ? opnd[MSB] : zn_src[MSB];

endmodule

// File: rtl/dec_alu_chk.sv
module dec_alu_chk
   import alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input logic [OP_W-1:0]  op_sel,
   input logic [WIDTH-1:0] ref_val,
   input logic [WIDTH-1:0] opnd,
   input logic             carry_in,
   input logic             dec_mode,
   input logic [WIDTH-1:0] result,
   input logic             c_out,
   input logic             c_we,
   input logic             z_out,
   input logic             z_we,
   input logic             n_out,
   input logic             n_we,
   input logic             v_out,
   input logic             v_we
);
   localparam int MSB    = WIDTH - 1;
   localparam int DIGITS = WIDTH / DIGIT_W;

   function automatic bit is_bcd(input logic [WIDTH-1:0] w);
      bit ok = 1'b1;
      for (int d = 0; d < DIGITS; d++)
         if (w[d*DIGIT_W +: DIGIT_W] > 4'd9) ok = 1'b0;
      return ok;
   endfunction

   always_comb begin
      if (!dec_mode && (op_sel == OP_ADD || op_sel == OP_SUB))
         p_zero_binary_r1: assert (z_out == (result == '0) && n_out == result[MSB])
            else $error("binary add/sub zero/negative do not follow result");

      if (dec_mode && op_sel == OP_ADD && is_bcd(ref_val) && is_bcd(opnd))
         p_dec_digits_r4: assert (is_bcd(result))
            else $error("decimal add produced a non-decimal digit");

      if (op_sel == OP_CMP)
         p_cmp_hold_r7: assert (result == ref_val && !v_we && c_out == (ref_val >= opnd))
            else $error("compare altered result, wrote overflow or wrong carry");

      if (op_sel == OP_BIT)
         p_bit_copy_r8: assert (n_out == opnd[MSB] && v_out == opnd[MSB-1] && !c_we)
            else $error("bit test flag copy wrong");

      if (op_sel inside {OP_AND, OP_OR, OP_XOR})
         p_logic_zn_r9: assert (!c_we && !v_we && z_we && n_we)
            else $error("logical op enables wrong");

      if (op_sel inside {OP_SHL, OP_ROL})
         p_left_carry_r10: assert (c_out == opnd[MSB] && c_we)
            else $error("left shift carry wrong");

      if (op_sel inside {OP_SHR, OP_ROR})
         p_right_carry_r10: assert (c_out == opnd[0] && c_we)
            else $error("right shift carry wrong");

      if (op_sel inside {OP_INC, OP_DEC, OP_PASS})
         p_step_zn_r11: assert (!c_we && !v_we && z_we && n_we)
            else $error("step/pass enables wrong");

      if (op_sel inside {OP_IDL0, OP_IDL1})
         p_idle_r12: assert (!c_we && !z_we && !n_we && !v_we && result == ref_val)
            else $error("idle code wrote a flag or changed the result");
   end
endmodule

bind dec_alu dec_alu_chk #(.WIDTH(WIDTH)) chk_i (
   .op_sel(op_sel), .ref_val(ref_val), .opnd(opnd), .carry_in(carry_in),
   .dec_mode(dec_mode), .result(result),
   .c_out(c_out), .c_we(c_we), .z_out(z_out), .z_we(z_we),
   .n_out(n_out), .n_we(n_we), .v_out(v_out), .v_we(v_we)
);

// File: tb/dec_alu_tb_top.sv
`timescale 1ns/100ps
module dec_alu_tb_top;

   localparam real CLK_PERIOD = 10.0;
   localparam int  WD_LIMIT   = 150000;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2.0) clk = ~clk;

   logic [3:0] op_sel;
   logic [7:0] ref_val, opnd, result;
   logic       carry_in, dec_mode;
   logic       c_out, c_we, z_out, z_we, n_out, n_we, v_out, v_we;

   dec_alu #(.WIDTH(8), .DECIMAL_EN(1'b1)) dut_i (
      .op_sel(op_sel), .ref_val(ref_val), .opnd(opnd), .carry_in(carry_in),
      .dec_mode(dec_mode), .result(result),
      .c_out(c_out), .c_we(c_we), .z_out(z_out), .z_we(z_we),
      .n_out(n_out), .n_we(n_we), .v_out(v_out), .v_we(v_we)
   );

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  finished = 1'b0;

   typedef struct packed {
      logic [7:0] res;
      logic c, cw, z, zw, n, nw, v, vw;
   } exp_t;

   function automatic int sgn(input int x);
      return (x >= 128) ? x - 256 : x;
   endfunction

   function automatic exp_t model(input int op, input int r, input int b,
                                  input int c, input int d);
      exp_t e;
      int s, ss, bin, lo, hi, w;
      e = '0;
      w = r;
      case (op)
         0: begin  // R1 R2 R4 R6
            s = r + b + c; bin = s % 256; ss = sgn(r) + sgn(b) + c;
            if (d != 0) begin
               lo = (r % 16) + (b % 16) + c;
               hi = (r / 16) + (b / 16) + ((lo >= 10) ? 1 : 0);
               w  = (hi % 10) * 16 + (lo % 10);
               e.c = (hi > 9);
            end else begin
               w = bin; e.c = (s > 255);
            end
            e.z = (bin == 0); e.n = (bin >= 128); e.v = (ss < -128 || ss > 127);
            {e.cw, e.zw, e.nw, e.vw} = 4'b1111;
         end
         1: begin  // R2 R3 R5 R6
            s = 256 + r - b + c - 1; bin = s % 256; ss = sgn(r) - sgn(b) + c - 1;
            if (d != 0) begin
               lo = 10 + (r % 16) - (b % 16) + c - 1;
               hi = 10 + (r / 16) - (b / 16) - ((lo < 10) ? 1 : 0);
               w  = (hi % 10) * 16 + (lo % 10);
               e.c = (hi >= 10);
            end else begin
               w = bin; e.c = (s > 255);
            end
            e.z = (bin == 0); e.n = (bin >= 128); e.v = (ss < -128 || ss > 127);
            {e.cw, e.zw, e.nw, e.vw} = 4'b1111;
         end
         2: begin  // R7
            bin = (r - b + 256) % 256;
            e.c = (r >= b); e.z = (bin == 0); e.n = (bin >= 128);
            {e.cw, e.zw, e.nw} = 3'b111;
         end
         3: begin  // R8
            e.z = ((r & b) == 0); e.n = ((b >> 7) & 1); e.v = ((b >> 6) & 1);
            {e.zw, e.nw, e.vw} = 3'b111;
         end
         4, 5, 6: begin  // R9
            w = (op == 4) ? (r & b) : (op == 5) ? (r | b) : (r ^ b);
            {e.zw, e.nw} = 2'b11;
         end
         7, 8, 9, 10: begin  // R10
            if (op == 7 || op == 9) begin
               w = ((b << 1) & 255) | ((op == 9) ? c : 0);
               e.c = (b >> 7) & 1;
            end else begin
               w = (b >> 1) | ((op == 10) ? (c << 7) : 0);
               e.c = b & 1;
            end
            {e.cw, e.zw, e.nw} = 3'b111;
         end
         11, 12, 13: begin  // R11
            w = (op == 11) ? (b + 1) % 256 : (op == 12) ? (b + 255) % 256 : b;
            {e.zw, e.nw} = 2'b11;
         end
         default: ;  // R12 idle codes
      endcase
      e.res = w[7:0];
      if (op >= 4 && op <= 13) begin
         e.z = (w == 0); e.n = (w >= 128);
      end
      return e;
   endfunction

   function automatic string tag_of(input int op, input int d);
      case (op)
         0:       return (d != 0) ? "R4/R6/R12" : "R1/R2/R12";
         1:       return (d != 0) ? "R5/R6/R12" : "R3/R2/R12";
         2:       return "R7";
         3:       return "R8";
         4, 5, 6: return "R9";
         7, 8, 9, 10: return "R10";
         11, 12, 13:  return "R11";
         default: return "R12";
      endcase
   endfunction

   task automatic run_vec(input int op, input int r, input int b,
                          input int c, input int d);
      exp_t e;
      bit   bad;
      e = model(op, r, b, c, d);
      op_sel   = op[3:0];
      ref_val  = r[7:0];
      opnd     = b[7:0];
      carry_in = c[0];
      dec_mode = d[0];
      #0.5;
      n_tests++;
      bad = (result !== e.res) || (c_we !== e.cw) || (z_we !== e.zw) ||
            (n_we !== e.nw) || (v_we !== e.vw) ||
            (e.cw && c_out !== e.c) || (e.zw && z_out !== e.z) ||
            (e.nw && n_out !== e.n) || (e.vw && v_out !== e.v);
      if (bad) begin
         n_fail++;
         $display("FAIL %s op=%0d ref=%02h opnd=%02h cin=%0d dec=%0d got res=%02h C=%0b/%0b Z=%0b/%0b N=%0b/%0b V=%0b/%0b exp res=%02h C=%0b/%0b Z=%0b/%0b N=%0b/%0b V=%0b/%0b",
                  tag_of(op, d), op, r, b, c, d,
                  result, c_out, c_we, z_out, z_we, n_out, n_we, v_out, v_we,
                  e.res, e.c, e.cw, e.z, e.zw, e.n, e.nw, e.v, e.vw);
      end
      #0.5;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   // watchdog
   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc >= WD_LIMIT) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired after %0d cycles, expected completion", cyc);
            finish_run();
         end
      end
   end

   initial begin
      op_sel = '0; ref_val = '0; opnd = '0; carry_in = 1'b0; dec_mode = 1'b0;
      #2.2;
      // quiescent vector: all-zero add gives zero result and zero flag (R1)
      run_vec(0, 0, 0, 0, 0);

      // binary add, subtract and compare over every word pair (R1 R2 R3 R7)
      for (int op = 0; op < 3; op++)
         for (int r = 0; r < 256; r++)
            for (int b = 0; b < 256; b++)
               run_vec(op, r, b, (r ^ b ^ (b >> 3)) & 1, 0);

      // decimal add and subtract over all valid two-digit values (R4 R5 R6)
      for (int op = 0; op < 2; op++)
         for (int rd = 0; rd < 100; rd++)
            for (int bd = 0; bd < 100; bd++)
               for (int c = 0; c < 2; c++)
                  run_vec(op, (rd / 10) * 16 + rd % 10, (bd / 10) * 16 + bd % 10, c, 1);

      // remaining codes, decimal flag toggled to show it has no effect (R8..R12)
      for (int op = 3; op < 16; op++)
         for (int r = 0; r < 256; r += 7)
            for (int b = 0; b < 256; b++)
               for (int c = 0; c < 2; c++)
                  run_vec(op, r, b, c, (b >> 1) & 1);

      // boundary corners (R2 R3 R10 R11)
      run_vec(0, 8'h7F, 8'h00, 1, 0);
      run_vec(1, 8'h80, 8'h00, 0, 0);
      run_vec(9, 8'h00, 8'h80, 1, 0);
      run_vec(10, 8'h00, 8'h01, 1, 0);
      run_vec(11, 8'h00, 8'hFF, 0, 0);
      run_vec(12, 8'h00, 8'h00, 0, 0);
      run_vec(0, 8'h99, 8'h01, 0, 1);
      run_vec(1, 8'h00, 8'h01, 1, 1);

      finish_run();
   end

endmodule